// File: doc/BRIEF.md
# Host-to-Engine Word Mailbox

This block is a two-way mailbox between a host register port and an internal engine. Traffic toward the engine goes through an upstream queue of 32-bit words. The host fills that queue through a data register and the engine drains it through a valid/ready pop port. Traffic toward the host goes through a downstream queue. The engine fills it through a valid/ready push port and the host drains it by reading a data register.

Each queue entry holds one data word and one end-of-transfer tag. The tag travels in order with the data, so a receiver knows where a transfer ends. The host places a marker in the upstream queue by writing a command register. The engine tags any downstream word it pushes. Each direction has a status word that gives the host the fill level and the flags it needs. A flush register empties both queues and clears the sticky overflow flag.

The host port uses byte offsets, and every transfer is a full word. Host reads return their data on the cycle after the request, together with a valid strobe.

Top module: `hostlink_mailbox`

## Requirements
- R1: After reset, both status words read 0x00100000: empty flag bit 20 is set, and the count (bits 19:16), full flag (bit 9), overflow flag (bit 8) and head-marker flag (bit 7) are clear. Also after reset, `up_valid` is 0, `dn_ready` is 1 and `host_rdata` is 0.
- R2: Host writes to offset 0x00 enqueue words upstream. The engine receives them in write order, each with `up_eot` at 0.
- R3: Upstream status bit 9 is set while the upstream queue holds 8 words. A data write or marker write made while it is full is dropped. The dropped write sets upstream status bit 8, which stays set until a flush.
- R4: Writing the value 1 to offset 0x08 enqueues a marker behind the words already written. The engine receives the marker as a word of value 0 with `up_eot` at 1. Any other value written to 0x08 has no effect.
- R5: Downstream status (offset 0x44) gives the entry count in bits 19:16, empty in bit 20 and full in bit 9. `dn_ready` is 0 while the queue holds 8 words, and a push offered while full is not stored.
- R6: A host read of offset 0x40 returns the head downstream word on `host_rdata`, with `host_rvalid` set, on the following cycle. The read removes that word. Words come out in push order.
- R7: Status bit 7 is set when the head entry of that queue carries the end-of-transfer tag. A single read of 0x40 returns the tagged word's data and removes it.
- R8: A read of 0x40 while the downstream queue is empty returns 0 and leaves the status unchanged.
- R9: Writing the value 1 to offset 0x0C empties both queues and clears the overflow flag. Any other value written there has no effect.
- R10: An engine push and a host read of 0x40 in the same cycle both take effect, and the count is unchanged.
- R11: Reads of offsets other than 0x04, 0x40 and 0x44 return 0. Host writes to offsets other than 0x00, 0x08 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Registered read word, valid one cycle after the request |
| host_rvalid | output | 1 | Marks the cycle that carries read data |
| up_valid | output | 1 | Upstream queue has a word for the engine |
| up_ready | input | 1 | Engine takes the upstream head word |
| up_data | output | 32 | Upstream head word |
| up_eot | output | 1 | Upstream head word is an end-of-transfer marker |
| dn_valid | input | 1 | Engine offers a downstream word |
| dn_ready | output | 1 | Downstream queue can store a word |
| dn_data | input | 32 | Downstream word from the engine |
| dn_eot | input | 1 | End-of-transfer tag for the offered word |

## Verification
On every cycle, the embedded properties check the following:
- a full queue keeps its count when offered a push;
- an empty queue stays empty when popped;
- a flush leaves both queues empty;
- the overflow flag stays set until a flush;
- read data follows each read request by one cycle;
- an empty downstream read returns zero.

Only the bench scenarios can show the rest:
- word ordering across both queues;
- that markers land behind earlier data;
- the exact status encodings;
- that a dropped ninth word never reappears;
- concurrent push and pop in one cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int WORD_W      = 32;
  localparam int CNT_FIELD_W = 4;

  // Host register offsets (bytes)
  localparam logic [7:0] OFS_UP_DATA = 8'h00;
  localparam logic [7:0] OFS_UP_STAT = 8'h04;
  localparam logic [7:0] OFS_UP_EOT  = 8'h08;
  localparam logic [7:0] OFS_FLUSH   = 8'h0C;
  localparam logic [7:0] OFS_DN_DATA = 8'h40;
  localparam logic [7:0] OFS_DN_STAT = 8'h44;

  // Status bit positions
  localparam int ST_EMPTY_BIT = 20;
  localparam int ST_CNT_LSB   = 16;
  localparam int ST_FULL_BIT  = 9;
  localparam int ST_OVF_BIT   = 8;
  localparam int ST_HEOT_BIT  = 7;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic [CNT_FIELD_W-1:0] cnt,
    input logic                   empty,
    input logic                   full,
    input logic                   head_eot,
    input logic                   ovf
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[ST_CNT_LSB +: CNT_FIELD_W] = cnt;
    w[ST_EMPTY_BIT] = empty;
    w[ST_FULL_BIT]  = full;
    w[ST_OVF_BIT]   = ovf;
    w[ST_HEOT_BIT]  = head_eot;
    return w;
  endfunction

endpackage

// File: rtl/mbx_word_fifo.sv
module mbx_word_fifo #(
  parameter int ENTRY_W = 33,
  parameter int DEPTH   = 8,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic [CW-1:0]      count,
  output logic               empty,
  output logic               full
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic               do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  // storage: write port only, no reset, so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop && !flush |=> count == $past(count));

  p_empty_pop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push && !flush |=> empty);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

  p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

endmodule

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] up_status,
  input  logic [WORD_W-1:0] dn_status,
  input  logic [WORD_W-1:0] dn_head_data,
  input  logic              dn_empty,
  output logic              up_wr,
  output logic              eot_wr,
  output logic              flush_wr,
  output logic              dn_rd,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  localparam logic [WORD_W-1:0] CMD_ONE = WORD_W'(1);

  logic              wr_req, rd_req;
  logic [WORD_W-1:0] rd_next;

  assign wr_req   = sel & we;
  assign rd_req   = sel & ~we;
  assign up_wr    = wr_req && (addr == ADDR_W'(OFS_UP_DATA));
  assign eot_wr   = wr_req && (addr == ADDR_W'(OFS_UP_EOT)) && (wdata == CMD_ONE);
  assign flush_wr = wr_req && (addr == ADDR_W'(OFS_FLUSH))  && (wdata == CMD_ONE);
  assign dn_rd    = rd_req && (addr == ADDR_W'(OFS_DN_DATA)) && !dn_empty;

  always_comb begin
    if (addr == ADDR_W'(OFS_UP_STAT))      rd_next = up_status;
    else if (addr == ADDR_W'(OFS_DN_STAT)) rd_next = dn_status;
    else if (addr == ADDR_W'(OFS_DN_DATA)) rd_next = dn_empty ? '0 : dn_head_data;
    else                                   rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= rd_next;
    end
  end

  p_rvalid_follows_r6: assert property (@(posedge clk) disable iff (rst)
    sel && !we |=> rvalid);

  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    sel && !we && addr == ADDR_W'(OFS_DN_DATA) && dn_empty |=> rdata == '0);

endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [31:0]       up_data,
  output logic              up_eot,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [31:0]       dn_data,
  input  logic              dn_eot
);

  localparam int ENTRY_W = WORD_W + 1;
  localparam int CW      = $clog2(DEPTH + 1);

  logic               up_wr, eot_wr, flush_wr, dn_rd;
  logic               up_push;
  logic [ENTRY_W-1:0] up_in, up_head, dn_head;
  logic [CW-1:0]      up_count, dn_count;
  logic               up_empty, up_full, dn_empty, dn_full;
  logic               ovf;
  logic [WORD_W-1:0]  up_status, dn_status;

  mbx_host_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .sel          (host_sel),
    .we           (host_we),
    .addr         (host_addr),
    .wdata        (host_wdata),
    .up_status    (up_status),
    .dn_status    (dn_status),
    .dn_head_data (dn_head[WORD_W-1:0]),
    .dn_empty     (dn_empty),
    .up_wr        (up_wr),
    .eot_wr       (eot_wr),
    .flush_wr     (flush_wr),
    .dn_rd        (dn_rd),
    .rdata        (host_rdata),
    .rvalid       (host_rvalid)
  );

  // marker entries carry a zero data word and a set tag
  assign up_push = up_wr | eot_wr;
  assign up_in   = eot_wr ? {1'b1, {WORD_W{1'b0}}} : {1'b0, host_wdata};

  mbx_word_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_upq (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_wr),
    .push      (up_push),
    .push_data (up_in),
    .pop       (up_ready),
    .head      (up_head),
    .count     (up_count),
    .empty     (up_empty),
    .full      (up_full)
  );

  mbx_word_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_dnq (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_wr),
    .push      (dn_valid),
    .push_data ({dn_eot, dn_data}),
    .pop       (dn_rd),
    .head      (dn_head),
    .count     (dn_count),
    .empty     (dn_empty),
    .full      (dn_full)
  );

  always_ff @(posedge clk) begin
    if (rst || flush_wr)          ovf <= 1'b0;
    else if (up_push && up_full)  ovf <= 1'b1;
  end

  assign up_status = pack_status(CNT_FIELD_W'(up_count), up_empty, up_full,
                                 up_head[WORD_W] & ~up_empty, ovf);
  assign dn_status = pack_status(CNT_FIELD_W'(dn_count), dn_empty, dn_full,
                                 dn_head[WORD_W] & ~dn_empty, 1'b0);

  assign up_valid = ~up_empty;
  assign up_data  = up_head[WORD_W-1:0];
  assign up_eot   = up_head[WORD_W];
  assign dn_ready = ~dn_full;

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ovf && !flush_wr |=> ovf);

  p_refused_push_r5: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready && !dn_rd && !flush_wr |=> dn_count == $past(dn_count));

  p_marker_word_zero_r4: assert property (@(posedge clk) disable iff (rst)
    eot_wr && up_empty && !flush_wr |=> up_valid && up_eot && up_data == '0);

endmodule

// File: tb/sim_hostlink_mailbox.sv
module sim_hostlink_mailbox;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_sel, host_we;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        up_valid, up_ready, up_eot;
  logic [31:0] up_data;
  logic        dn_valid, dn_ready, dn_eot;
  logic [31:0] dn_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  hostlink_mailbox u0 (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data), .up_eot(up_eot),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data), .dn_eot(dn_eot)
  );

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_POP = 2'd2, OP_PUSH = 2'd3;
  localparam logic [31:0] ST_EMPTY = 32'h0010_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] val;
    logic        eot;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_W,    8'h00, 32'hAAAA_0001, 1'b0, 4'd2},   // R2
    '{OP_W,    8'h00, 32'hAAAA_0002, 1'b0, 4'd2},   // R2
    '{OP_W,    8'h08, 32'h0000_0001, 1'b0, 4'd4},   // R4 marker
    '{OP_W,    8'h08, 32'h0000_0002, 1'b0, 4'd4},   // R4 ignored value
    '{OP_R,    8'h04, 32'h0003_0000, 1'b0, 4'd4},   // R4 count is 3
    '{OP_POP,  8'h00, 32'hAAAA_0001, 1'b0, 4'd2},   // R2
    '{OP_POP,  8'h00, 32'hAAAA_0002, 1'b0, 4'd2},   // R2
    '{OP_R,    8'h04, 32'h0001_0080, 1'b0, 4'd7},   // R7 marker at head
    '{OP_POP,  8'h00, 32'h0000_0000, 1'b1, 4'd4},   // R4
    '{OP_R,    8'h04, ST_EMPTY,      1'b0, 4'd1},   // R1
    '{OP_PUSH, 8'h00, 32'h1234_5678, 1'b0, 4'd5},   // R5
    '{OP_PUSH, 8'h00, 32'h0000_BEEF, 1'b1, 4'd5},   // R5
    '{OP_R,    8'h44, 32'h0002_0000, 1'b0, 4'd5},   // R5
    '{OP_R,    8'h40, 32'h1234_5678, 1'b0, 4'd6},   // R6
    '{OP_R,    8'h44, 32'h0001_0080, 1'b0, 4'd7},   // R7
    '{OP_R,    8'h40, 32'h0000_BEEF, 1'b0, 4'd7},   // R7
    '{OP_R,    8'h44, ST_EMPTY,      1'b0, 4'd7},   // R7 single read pops
    '{OP_R,    8'h40, 32'h0000_0000, 1'b0, 4'd8},   // R8
    '{OP_R,    8'h44, ST_EMPTY,      1'b0, 4'd8},   // R8
    '{OP_R,    8'h10, 32'h0000_0000, 1'b0, 4'd11},  // R11 unmapped read
    '{OP_W,    8'h44, 32'hFFFF_FFFF, 1'b0, 4'd11},  // R11 write to status
    '{OP_R,    8'h44, ST_EMPTY,      1'b0, 4'd11}   // R11
  };

  task automatic check(input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic read_check(input int rq, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic        v;
    host_read(a, d, v);
    check(rq, $sformatf("read %02h {rvalid,data}", a), {31'd0, v, d}, {31'd0, 1'b1, exp});
  endtask

  task automatic eng_pop(input int rq, input logic [31:0] exp, input logic exp_eot);
    @(negedge clk);
    check(rq, "engine pop {valid,eot,data}", {30'd0, up_valid, up_eot, up_data},
          {30'd0, 1'b1, exp_eot, exp});
    up_ready = 1'b1;
    @(negedge clk);
    up_ready = 1'b0;
  endtask

  task automatic eng_push(input int rq, input logic [31:0] d, input logic e);
    @(negedge clk);
    check(rq, "engine push ready", {63'd0, dn_ready}, 64'd1);
    dn_valid = 1'b1; dn_data = d; dn_eot = e;
    @(negedge clk);
    dn_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; host_sel = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    up_ready = 1'b0; dn_valid = 1'b0; dn_data = '0; dn_eot = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check(1, "reset up_valid", {63'd0, up_valid}, 64'd0);
    check(1, "reset dn_ready", {63'd0, dn_ready}, 64'd1);
    check(1, "reset rdata", {32'd0, host_rdata}, 64'd0);
    read_check(1, 8'h04, ST_EMPTY);
    read_check(1, 8'h44, ST_EMPTY);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W:    host_write(VEC[i].addr, VEC[i].val);
        OP_R:    read_check(int'(VEC[i].req), VEC[i].addr, VEC[i].val);
        OP_POP:  eng_pop(int'(VEC[i].req), VEC[i].val, VEC[i].eot);
        default: eng_push(int'(VEC[i].req), VEC[i].val, VEC[i].eot);
      endcase
    end

    // R3 upstream full and overflow
    for (int i = 0; i < 8; i++) host_write(8'h00, 32'hC000_0000 + 32'(i));
    read_check(3, 8'h04, 32'h0008_0200);
    host_write(8'h00, 32'hDEAD_DEAD);
    read_check(3, 8'h04, 32'h0008_0300);
    host_write(8'h08, 32'h1);  // R3 marker also dropped
    for (int i = 0; i < 8; i++) eng_pop(3, 32'hC000_0000 + 32'(i), 1'b0);
    @(negedge clk);
    check(3, "dropped words absent", {63'd0, up_valid}, 64'd0);
    read_check(3, 8'h04, 32'h0010_0100);

    // R9 flush
    host_write(8'h0C, 32'h2);
    read_check(9, 8'h04, 32'h0010_0100);
    for (int i = 0; i < 3; i++) host_write(8'h00, 32'h5500_0000 + 32'(i));
    eng_push(9, 32'h6600_0001, 1'b0);
    eng_push(9, 32'h6600_0002, 1'b1);
    host_write(8'h0C, 32'h1);
    read_check(9, 8'h04, ST_EMPTY);
    read_check(9, 8'h44, ST_EMPTY);
    @(negedge clk);
    check(9, "flush up_valid", {63'd0, up_valid}, 64'd0);

    // R5 downstream full
    for (int i = 0; i < 8; i++) eng_push(5, 32'h7700_0000 + 32'(i), 1'b0);
    @(negedge clk);
    check(5, "full dn_ready", {63'd0, dn_ready}, 64'd0);
    dn_valid = 1'b1; dn_data = 32'hBAD0_BAD0; dn_eot = 1'b0;
    @(negedge clk);
    dn_valid = 1'b0;
    read_check(5, 8'h44, 32'h0008_0200);
    for (int i = 0; i < 8; i++) read_check(6, 8'h40, 32'h7700_0000 + 32'(i)); // R6 order
    read_check(5, 8'h44, ST_EMPTY);

    // R10 simultaneous push and read
    eng_push(10, 32'h1111_0000, 1'b0);
    @(negedge clk);
    dn_valid = 1'b1; dn_data = 32'h2222_0000; dn_eot = 1'b0;
    host_sel = 1'b1; host_we = 1'b0; host_addr = 8'h40;
    @(negedge clk);
    dn_valid = 1'b0; host_sel = 1'b0;
    check(10, "concurrent read data", {32'd0, host_rdata}, {32'd0, 32'h1111_0000});
    read_check(10, 8'h44, 32'h0001_0000);
    read_check(10, 8'h40, 32'h2222_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule